// File: doc/BRIEF.md
# Character-Synchronous Receive Front End with SYN Hunt and Strip

This block is the receive side of a character-oriented synchronous serial link. Each pulse of `rx_tick` marks a rising edge of the receive bit clock, and the serial input bit is taken on that pulse. After the receiver is enabled, the block hunts bit by bit for a programmed SYN1 pattern. Single-SYN mode synchronises on SYN1 alone. Double-SYN mode needs SYN1 followed directly by SYN2. Once synchronised, the block assembles characters of 5 to 8 bits, with an optional parity bit, into a holding register.

The host sees a ready flag, a sticky SYN-detect flag, a parity-error flag and an overrun flag. The host clears them with a data-read strobe and a status-read strobe. SYN characters can be kept out of the holding register. An external jam-sync mode turns off pattern detection: a rising edge on a dedicated input forces character alignment at the next bit clock.

Top module: `syn_rx_front`

## Requirements
- R1: While `rx_enable` is 0, the block sits idle. One cycle after `rx_enable` is seen low, `rx_ready`, `syn_det`, `par_err` and `rx_ovr` are all 0. Raising `rx_enable` starts a new hunt with an empty shift register.
- R2: Bits arrive least significant first. In hunt, the last L received bits (L = 5 + `cfg_len`, so `cfg_len` 0..3 selects 5..8 bits) are compared with the low L bits of `cfg_syn1` after every bit. A match can occur at any bit alignment.
- R3: In single-SYN mode (`cfg_dual_syn`=0), a SYN1 match sets `syn_det` one cycle after the tick that carries the last matching bit. The SYN1 that achieves synchronisation never reaches the holding register.
- R4: In double-SYN mode, the frame that directly follows the SYN1 match must equal SYN2 to set `syn_det` and synchronise. Any other frame returns the block to hunt, so SYN1, SYN1, SYN2 does not synchronise. The synchronising SYN2 is not transferred.
- R5: Once synchronised, each frame is loaded into `rx_char` and sets `rx_ready`. Bit i of `rx_char` is the i-th data bit received, and the bits at and above L are 0. `rx_char` changes only on a tick.
- R6: When `cfg_par_en`=1, each frame carries one parity bit after its L data bits. `cfg_par_odd` selects odd (1) or even (0) parity. `par_err` shows the check result for the most recently transferred character. The parity bit that follows a hunted SYN1 is consumed and not checked.
- R7: `rd_data` clears `rx_ready`. A transfer while `rx_ready` is 1 and `rd_data` is 0 sets `rx_ovr` and overwrites `rx_char`. `rd_status` clears `rx_ovr` and `syn_det`. In every one of these cases a set in the same cycle wins over a clear.
- R8: While synchronised in internal mode, `syn_det` is set again by a later SYN sequence. In single mode this is a character equal to SYN1. In double mode it is a SYN2 character that directly follows a SYN1 character.
- R9: With `cfg_strip`=1, characters equal to SYN1 (and, in double mode, characters equal to SYN2) are not transferred and leave `rx_ready` unchanged. With `cfg_strip`=0, they are transferred like data.
- R10: With `cfg_ext_sync`=1, no pattern detection or stripping takes place. A rising edge on `ext_sync_in` forces synchronisation at the next tick, and the bit on that tick becomes data bit 0. This also sets `syn_det`, which stays set until `rd_status`, even across `rd_data`.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receiver enable; a rise starts hunt |
| rx_tick | input | 1 | One-cycle strobe marking a receive bit clock edge |
| rx_bit | input | 1 | Serial data, sampled when `rx_tick` is 1 |
| cfg_syn1 | input | DATA_W | First sync pattern |
| cfg_syn2 | input | DATA_W | Second sync pattern (double mode) |
| cfg_dual_syn | input | 1 | 1 = SYN1 then SYN2 required |
| cfg_strip | input | 1 | 1 = drop SYN characters |
| cfg_len | input | LSEL_W | Character length code, length = 5 + code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_ext_sync | input | 1 | External jam-sync mode |
| ext_sync_in | input | 1 | Jam-sync request, rising-edge active |
| rd_data | input | 1 | Host read of the holding register |
| rd_status | input | 1 | Host read of status flags |
| rx_char | output | DATA_W | Holding register |
| rx_ready | output | 1 | Character waiting |
| syn_det | output | 1 | Sync detected (sticky) |
| par_err | output | 1 | Parity error of last transferred character |
| rx_ovr | output | 1 | Overrun (sticky) |

## Verification
The hardest case to reach is the rejected double-SYN sequence. The block has to be carried through SYN1, into the verify state, back into hunt, and then kept from finding a false match inside the SYN2 bits that follow. The bench picks SYN patterns whose shifted bit windows cannot alias, and it clears the shift register on re-enable. This makes every hunt window predictable. Parity after a hunted SYN1 is sent deliberately wrong, to show that the bit is consumed rather than checked. Jam sync is reached by first streaming a real SYN1 that must be ignored.

// File: rtl/syn_rx_pkg.sv
package syn_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_HUNT   = 3'd1,
    ST_PSKIP  = 3'd2,
    ST_VERIFY = 3'd3,
    ST_SYNC   = 3'd4
  } rx_state_e;
endpackage

// File: rtl/syn_rx_shift.sv
module syn_rx_shift #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sr_clr,
  input  logic              shift_en,
  input  logic              bit_in,
  input  logic [CNT_W-1:0]  len_bits,
  output logic [DATA_W-1:0] len_mask,
  output logic [DATA_W-1:0] win_cur,
  output logic [DATA_W-1:0] win_nxt
);
  logic [DATA_W-1:0] sr_q, sr_d, sr_sh;
  logic [CNT_W-1:0]  gap;

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign len_mask[g] = (len_bits > CNT_W'(g));
  end

  always_comb begin
    sr_sh = {bit_in, sr_q[DATA_W-1:1]};
    sr_d  = sr_q;
    if (sr_clr)        sr_d = '0;
    else if (shift_en) sr_d = sr_sh;
  end

  // Newest bit sits at the top; the last L bits are aligned down to bit 0.
  assign gap     = CNT_W'(DATA_W) - len_bits;
  assign win_cur = (sr_q  >> gap) & len_mask;
  assign win_nxt = (sr_sh >> gap) & len_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end
endmodule

// File: rtl/syn_rx_ctrl.sv
module syn_rx_ctrl
  import syn_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic              rx_tick,
  input  logic              bit_in,
  input  logic              cfg_dual,
  input  logic              cfg_strip,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_ext,
  input  logic              ext_sync_in,
  input  logic [DATA_W-1:0] syn1_m,
  input  logic [DATA_W-1:0] syn2_m,
  input  logic [CNT_W-1:0]  len_bits,
  input  logic [DATA_W-1:0] win_cur,
  input  logic [DATA_W-1:0] win_nxt,
  output logic              sr_clr,
  output logic              shift_en,
  output logic              xfer,
  output logic [DATA_W-1:0] xfer_char,
  output logic              xfer_perr,
  output logic              set_syn
);
  rx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             ext_q;
  logic             prev1_q, prev1_d;

  logic ext_edge, pend_eff, data_phase, frame_last;
  logic is1, is2, strip;

  always_comb begin
    ext_edge   = ext_sync_in & ~ext_q;
    pend_eff   = pend_q | ext_edge;
    data_phase = (cnt_q < len_bits);
    frame_last = cfg_par_en ? (cnt_q == len_bits)
                            : (cnt_q == (len_bits - 1'b1));
    xfer_char  = cfg_par_en ? win_cur : win_nxt;
    xfer_perr  = cfg_par_en & ((^win_cur) ^ bit_in ^ cfg_par_odd);
    is1        = (xfer_char == syn1_m);
    is2        = (xfer_char == syn2_m);
  end

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    pend_d   = pend_q & cfg_ext;
    prev1_d  = prev1_q;
    sr_clr   = 1'b0;
    shift_en = 1'b0;
    xfer     = 1'b0;
    set_syn  = 1'b0;
    strip    = 1'b0;
    if (!rx_enable) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      pend_d  = 1'b0;
      prev1_d = 1'b0;
      sr_clr  = 1'b1;
    end else if (state_q == ST_IDLE) begin
      state_d = ST_HUNT;
      cnt_d   = '0;
      pend_d  = 1'b0;
      sr_clr  = 1'b1;
    end else begin
      if (cfg_ext && ext_edge) pend_d = 1'b1;
      if (rx_tick) begin
        if (cfg_ext && pend_eff) begin
          // jam sync: this bit is data bit 0 of a new character
          state_d  = ST_SYNC;
          shift_en = 1'b1;
          cnt_d    = CNT_W'(1);
          pend_d   = 1'b0;
          prev1_d  = 1'b0;
          set_syn  = 1'b1;
        end else begin
          case (state_q)
            ST_HUNT: begin
              shift_en = 1'b1;
              if (!cfg_ext && (win_nxt == syn1_m)) begin
                cnt_d = '0;
                if (cfg_par_en)    state_d = ST_PSKIP;
                else if (cfg_dual) state_d = ST_VERIFY;
                else               state_d = ST_SYNC;
                if (!cfg_dual) set_syn = 1'b1;
              end
            end
            ST_PSKIP: begin
              cnt_d   = '0;
              state_d = cfg_dual ? ST_VERIFY : ST_SYNC;
            end
            ST_VERIFY: begin
              if (data_phase) shift_en = 1'b1;
              if (frame_last) begin
                cnt_d = '0;
                if (is2) begin
                  state_d = ST_SYNC;
                  set_syn = 1'b1;
                  prev1_d = 1'b0;
                end else begin
                  state_d = ST_HUNT;
                end
              end else begin
                cnt_d = cnt_q + 1'b1;
              end
            end
            ST_SYNC: begin
              if (data_phase) shift_en = 1'b1;
              if (frame_last) begin
                cnt_d = '0;
                if (!cfg_ext) begin
                  if (cfg_dual) set_syn = is2 & prev1_q;
                  else          set_syn = is1;
                  strip = cfg_strip & (is1 | (cfg_dual & is2));
                end
                xfer    = ~strip;
                prev1_d = is1;
              end else begin
                cnt_d = cnt_q + 1'b1;
              end
            end
            default: state_d = ST_IDLE;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      ext_q   <= 1'b0;
      prev1_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      ext_q   <= ext_sync_in;
      prev1_q <= prev1_d;
    end
  end
endmodule

// File: rtl/syn_rx_hold.sv
module syn_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              xfer,
  input  logic [DATA_W-1:0] xfer_char,
  input  logic              xfer_perr,
  input  logic              set_syn,
  input  logic              rd_data,
  input  logic              rd_status,
  output logic [DATA_W-1:0] rx_char,
  output logic              rx_ready,
  output logic              syn_det,
  output logic              par_err,
  output logic              rx_ovr
);
  logic [DATA_W-1:0] char_q, char_d;
  logic rdy_q, rdy_d, syn_q, syn_d, perr_q, perr_d, ovr_q, ovr_d;

  always_comb begin
    char_d = xfer ? xfer_char : char_q;
    if (clr)          rdy_d = 1'b0;
    else if (xfer)    rdy_d = 1'b1;
    else if (rd_data) rdy_d = 1'b0;
    else              rdy_d = rdy_q;
    if (clr)                          ovr_d = 1'b0;
    else if (xfer && rdy_q && !rd_data) ovr_d = 1'b1;
    else if (rd_status)               ovr_d = 1'b0;
    else                              ovr_d = ovr_q;
    if (clr)            syn_d = 1'b0;
    else if (set_syn)   syn_d = 1'b1;
    else if (rd_status) syn_d = 1'b0;
    else                syn_d = syn_q;
    if (clr)       perr_d = 1'b0;
    else if (xfer) perr_d = xfer_perr;
    else           perr_d = perr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      char_q <= '0;
      rdy_q  <= 1'b0;
      syn_q  <= 1'b0;
      perr_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      char_q <= char_d;
      rdy_q  <= rdy_d;
      syn_q  <= syn_d;
      perr_q <= perr_d;
      ovr_q  <= ovr_d;
    end
  end

  assign rx_char  = char_q;
  assign rx_ready = rdy_q;
  assign syn_det  = syn_q;
  assign par_err  = perr_q;
  assign rx_ovr   = ovr_q;
endmodule

// File: rtl/syn_rx_front.sv
module syn_rx_front #(
  parameter int DATA_W = 8,
  parameter int LSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic              rx_tick,
  input  logic              rx_bit,
  input  logic [DATA_W-1:0] cfg_syn1,
  input  logic [DATA_W-1:0] cfg_syn2,
  input  logic              cfg_dual_syn,
  input  logic              cfg_strip,
  input  logic [LSEL_W-1:0] cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_ext_sync,
  input  logic              ext_sync_in,
  input  logic              rd_data,
  input  logic              rd_status,
  output logic [DATA_W-1:0] rx_char,
  output logic              rx_ready,
  output logic              syn_det,
  output logic              par_err,
  output logic              rx_ovr
);
  localparam int MIN_LEN = DATA_W - (1 << LSEL_W) + 1;
  localparam int CNT_W   = $clog2(DATA_W + 2);

  logic              rst_s1, rst_s2;
  logic [CNT_W-1:0]  len_bits;
  logic [DATA_W-1:0] len_mask, win_cur, win_nxt, syn1_m, syn2_m, xfer_char;
  logic              sr_clr, shift_en, xfer, xfer_perr, set_syn;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  assign len_bits = CNT_W'(MIN_LEN) + CNT_W'(cfg_len);
  assign syn1_m   = cfg_syn1 & len_mask;
  assign syn2_m   = cfg_syn2 & len_mask;

  syn_rx_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_s2),
    .sr_clr   (sr_clr),
    .shift_en (shift_en),
    .bit_in   (rx_bit),
    .len_bits (len_bits),
    .len_mask (len_mask),
    .win_cur  (win_cur),
    .win_nxt  (win_nxt)
  );

  syn_rx_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_s2),
    .rx_enable   (rx_enable),
    .rx_tick     (rx_tick),
    .bit_in      (rx_bit),
    .cfg_dual    (cfg_dual_syn),
    .cfg_strip   (cfg_strip),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .cfg_ext     (cfg_ext_sync),
    .ext_sync_in (ext_sync_in),
    .syn1_m      (syn1_m),
    .syn2_m      (syn2_m),
    .len_bits    (len_bits),
    .win_cur     (win_cur),
    .win_nxt     (win_nxt),
    .sr_clr      (sr_clr),
    .shift_en    (shift_en),
    .xfer        (xfer),
    .xfer_char   (xfer_char),
    .xfer_perr   (xfer_perr),
    .set_syn     (set_syn)
  );

  syn_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_s2),
    .clr       (~rx_enable),
    .xfer      (xfer),
    .xfer_char (xfer_char),
    .xfer_perr (xfer_perr),
    .set_syn   (set_syn),
    .rd_data   (rd_data),
    .rd_status (rd_status),
    .rx_char   (rx_char),
    .rx_ready  (rx_ready),
    .syn_det   (syn_det),
    .par_err   (par_err),
    .rx_ovr    (rx_ovr)
  );
endmodule

// File: rtl/syn_rx_sva.sv
module syn_rx_sva #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_enable,
  input logic              rx_tick,
  input logic              rd_data,
  input logic              rd_status,
  input logic [DATA_W-1:0] rx_char,
  input logic              rx_ready,
  input logic              syn_det,
  input logic              rx_ovr
);
  a_r1_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> (!rx_ready && !syn_det));

  a_r7_read_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !rx_tick) |=> !rx_ready);

  a_r7_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !rx_tick) |=> (!rx_ovr && !syn_det));

  a_r7_overrun_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr) |-> $past(rx_ready));

  a_r5_char_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_tick |=> $stable(rx_char));

  a_r5_ready_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(rx_tick));

  a_r10_syn_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(syn_det) |-> $past(rx_tick));
endmodule

bind syn_rx_front syn_rx_sva #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_enable (rx_enable),
  .rx_tick   (rx_tick),
  .rd_data   (rd_data),
  .rd_status (rd_status),
  .rx_char   (rx_char),
  .rx_ready  (rx_ready),
  .syn_det   (syn_det),
  .rx_ovr    (rx_ovr)
);

// File: tb/sim_syn_rx_front.sv
`timescale 1ns/1ps
module sim_syn_rx_front;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_enable = 1'b0, rx_tick = 1'b0, rx_bit = 1'b0;
  logic [7:0] cfg_syn1 = 8'h16, cfg_syn2 = 8'h32;
  logic       cfg_dual_syn = 1'b0, cfg_strip = 1'b0;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_ext_sync = 1'b0;
  logic       ext_sync_in = 1'b0, rd_data = 1'b0, rd_status = 1'b0;
  logic [7:0] rx_char;
  logic       rx_ready, syn_det, par_err, rx_ovr;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  syn_rx_front u0 (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .rx_tick(rx_tick),
    .rx_bit(rx_bit), .cfg_syn1(cfg_syn1), .cfg_syn2(cfg_syn2),
    .cfg_dual_syn(cfg_dual_syn), .cfg_strip(cfg_strip), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_ext_sync(cfg_ext_sync), .ext_sync_in(ext_sync_in),
    .rd_data(rd_data), .rd_status(rd_status), .rx_char(rx_char),
    .rx_ready(rx_ready), .syn_det(syn_det), .par_err(par_err), .rx_ovr(rx_ovr)
  );

  // {strip, char, expect ready, expect syn_det}; single mode, 8-bit, SYN1=16
  localparam logic [10:0] VEC [6] = '{
    {1'b0, 8'h41, 1'b1, 1'b0},
    {1'b0, 8'h16, 1'b1, 1'b1},
    {1'b1, 8'h16, 1'b0, 1'b1},
    {1'b1, 8'hA5, 1'b1, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b0},
    {1'b0, 8'hFF, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    rx_bit  = b;
    rx_tick = 1'b1;
    @(negedge clk);
    rx_tick = 1'b0;
  endtask

  task automatic send_char(input logic [7:0] c, input int n, input logic pb);
    for (int i = 0; i < n; i++) send_bit(c[i]);
    if (cfg_par_en) send_bit(pb);
  endtask

  task automatic pulse_rd(input logic d, input logic s);
    @(negedge clk);
    rd_data = d;
    rd_status = s;
    @(negedge clk);
    rd_data = 1'b0;
    rd_status = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk);
    rx_enable = 1'b0;
    @(negedge clk);
    rx_enable = 1'b1;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1..all actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 rx_char", rx_char, 0);
    chk("R11 rx_ready", rx_ready, 0);
    chk("R11 syn_det", syn_det, 0);
    chk("R11 par_err", par_err, 0);
    chk("R11 rx_ovr", rx_ovr, 0);

    // R2/R3: junk bits then SYN1 at an odd alignment
    rx_enable = 1'b1;
    @(negedge clk);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    send_char(8'h16, 8, 1'b0);
    chk("R3 syn_det after hunt", syn_det, 1);
    chk("R3 hunted SYN1 not stored", rx_ready, 0);
    pulse_rd(1'b0, 1'b1);

    // R5/R8/R9 table walk
    for (int i = 0; i < 6; i++) begin
      cfg_strip = VEC[i][10];
      send_char(VEC[i][9:2], 8, 1'b0);
      chk("R5 R9 ready", rx_ready, VEC[i][1]);
      if (VEC[i][1]) chk("R5 char", rx_char, VEC[i][9:2]);
      chk("R8 syn_det", syn_det, VEC[i][0]);
      pulse_rd(1'b1, 1'b1);
    end
    cfg_strip = 1'b0;

    // R7 overrun
    send_char(8'h11, 8, 1'b0);
    send_char(8'h22, 8, 1'b0);
    chk("R7 overrun set", rx_ovr, 1);
    chk("R7 newest char kept", rx_char, 8'h22);
    pulse_rd(1'b0, 1'b1);
    chk("R7 status read clears overrun", rx_ovr, 0);
    chk("R7 ready kept by status read", rx_ready, 1);
    pulse_rd(1'b1, 1'b0);
    chk("R7 data read clears ready", rx_ready, 0);

    // R1 disable while holding data and sync flag
    send_char(8'h16, 8, 1'b0);
    @(negedge clk);
    rx_enable = 1'b0;
    @(negedge clk);
    chk("R1 ready cleared", rx_ready, 0);
    chk("R1 syn_det cleared", syn_det, 0);

    // R6 parity, even then odd; SYN1 parity bit deliberately wrong
    cfg_par_en = 1'b1;
    cfg_par_odd = 1'b0;
    restart();
    send_char(8'h16, 8, 1'b0);
    chk("R6 sync with unchecked parity", syn_det, 1);
    send_char(8'h41, 8, 1'b0);
    chk("R6 char with parity", rx_char, 8'h41);
    chk("R6 even ok", par_err, 0);
    pulse_rd(1'b1, 1'b1);
    send_char(8'h43, 8, 1'b0);
    chk("R6 even bad", par_err, 1);
    pulse_rd(1'b1, 1'b1);
    cfg_par_odd = 1'b1;
    send_char(8'h43, 8, 1'b0);
    chk("R6 odd ok", par_err, 0);
    cfg_par_en = 1'b0;
    cfg_par_odd = 1'b0;

    // R5 five-bit characters
    cfg_len = 2'd0;
    restart();
    send_char(8'h16, 5, 1'b0);
    chk("R2 five-bit hunt", syn_det, 1);
    send_char(8'hFB, 5, 1'b0);
    chk("R5 upper bits zero", rx_char, 8'h1B);
    cfg_len = 2'd3;

    // R4 double SYN
    cfg_dual_syn = 1'b1;
    restart();
    send_char(8'h16, 8, 1'b0);
    send_char(8'h16, 8, 1'b0);
    send_char(8'h32, 8, 1'b0);
    chk("R4 SYN1 SYN1 SYN2 no sync", syn_det, 0);
    chk("R4 nothing stored", rx_ready, 0);
    send_char(8'h16, 8, 1'b0);
    send_char(8'h32, 8, 1'b0);
    chk("R4 SYN1 SYN2 syncs", syn_det, 1);
    chk("R4 SYN2 not stored", rx_ready, 0);
    pulse_rd(1'b0, 1'b1);
    send_char(8'h16, 8, 1'b0);
    chk("R8 lone SYN1 in double mode", syn_det, 0);
    chk("R9 SYN1 kept without strip", rx_char, 8'h16);
    pulse_rd(1'b1, 1'b0);
    send_char(8'h32, 8, 1'b0);
    chk("R8 SYN1 SYN2 resync", syn_det, 1);
    pulse_rd(1'b1, 1'b1);
    cfg_strip = 1'b1;
    send_char(8'h16, 8, 1'b0);
    send_char(8'h32, 8, 1'b0);
    chk("R9 double strip", rx_ready, 0);
    chk("R9 strip still detects", syn_det, 1);
    cfg_strip = 1'b0;
    cfg_dual_syn = 1'b0;

    // R10 external jam sync
    cfg_ext_sync = 1'b1;
    restart();
    send_char(8'h16, 8, 1'b0);
    chk("R10 pattern ignored", syn_det, 0);
    @(negedge clk); ext_sync_in = 1'b1;
    @(negedge clk); ext_sync_in = 1'b0;
    @(negedge clk);
    chk("R10 waits for tick", syn_det, 0);
    send_char(8'h5A, 8, 1'b0);
    chk("R10 char aligned to edge", rx_char, 8'h5A);
    chk("R10 ready", rx_ready, 1);
    chk("R10 syn_det set", syn_det, 1);
    pulse_rd(1'b1, 1'b0);
    chk("R10 syn_det survives data read", syn_det, 1);
    pulse_rd(1'b0, 1'b1);
    chk("R10 syn_det cleared by status read", syn_det, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule